// File: doc/BRIEF.md
# Per-DIMM Clock-Enable State Tracker

This block watches the decoded southbound command slots of a buffered memory channel and keeps a mirror of which DIMM positions currently have their clock enable asserted. The state is one bit per DIMM position, eight positions by default. Each frame presents up to three command slots, A, B and C. Each slot carries a valid strobe, the 8-bit channel-command opcode, a DIMM select, a broadcast flag and an enable vector with one bit per DIMM.

When a slot carries the per-DIMM clock-enable command, the tracker updates its state. With the broadcast flag set, it loads the whole enable vector. With the flag clear, it changes only the bit of the selected DIMM. The three slots of a frame are applied in order, so a later slot overrides an earlier one. For every slot that updates the state, the block raises a one-cycle event that reports the affected DIMM, or reports that all DIMMs were affected. A debug or monitoring fabric can use these outputs to follow DIMM power state without decoding the command stream itself.

Top module: `cke_dimm_tracker`

## Requirements
- R1: While the synchronous reset is high, and in the first cycle after it, all enable bits and all event outputs are 0.
- R2: A slot is an update only when its valid bit is 1 and its opcode matches binary 0000_111x, so both 8'h0E and 8'h0F are accepted. A matching opcode with valid low changes nothing.
- R3: An update with broadcast = 1 loads all enable bits from that slot's enable vector. Bit d of the vector belongs to DIMM d.
- R4: An update with broadcast = 0 copies only bit `sel` of the slot's enable vector into the state. Every other bit keeps its value.
- R5: Any other opcode leaves the state unchanged and raises no event. This includes the per-rank clock-enable command 0000_110x (8'h0C and 8'h0D).
- R6: Slots are applied in the order A (index 0), B (index 1), C (index 2) within a cycle. Where two slots touch the same DIMM, the later slot wins.
- R7: The result of the slots presented at a clock edge is visible on `cke_state` right after that edge, one register stage.
- R8: For each updating slot s, `upd_pulse[s]` is 1 for exactly the cycle in which the new state appears. In that cycle `upd_all[s]` equals the slot's broadcast bit, and `upd_dimm[s]` carries the select value for a single-DIMM update or 0 for a broadcast. For a slot that does not update, all three outputs are 0.
- R9: Each select value from 0 to 7 addresses its own DIMM position.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| slot_valid | input | 3 | Per-slot valid; bit 0 is slot A |
| slot_cmd | input | 24 | Opcodes; bits [8s+7:8s] belong to slot s |
| slot_sel | input | 9 | DIMM selects; bits [3s+2:3s] belong to slot s |
| slot_bcast | input | 3 | Per-slot broadcast flag |
| slot_enable | input | 24 | Enable vectors; bits [8s+7:8s] belong to slot s |
| cke_state | output | 8 | Current enable bit per DIMM |
| upd_pulse | output | 3 | One-cycle update event per slot |
| upd_dimm | output | 9 | DIMM index per slot event, 0 for broadcast |
| upd_all | output | 3 | Per-slot event was a broadcast |

## Verification
Some properties are checked on every cycle. Every event must trace back to a valid slot that carried the per-DIMM opcode one cycle earlier. When no event fires, the state must hold. A lone single-DIMM event may change no bit other than the one it names. A broadcast that no later slot overrides must leave the state equal to its vector. Other behaviour only shows up in the bench scenarios. These are: the exact merged value when several slots hit the same DIMM, the rejection of the per-rank opcode and of unstrobed slots, the coverage of every select value, and the reset taking effect in the middle of a run.

// File: rtl/cke_track_pkg.sv
package cke_track_pkg;

  // Channel-command opcode width is fixed by the frame format.
  localparam int unsigned CMD_W = 8;

  // Per-DIMM clock-enable command: upper seven bits must equal 0000_111.
  localparam logic [CMD_W-1:0] DIMM_CKE_CODE = 8'h0E;
  localparam logic [CMD_W-1:0] DIMM_CKE_MASK = 8'hFE;

  function automatic logic is_dimm_cke(input logic [CMD_W-1:0] op);
    return (op & DIMM_CKE_MASK) == DIMM_CKE_CODE;
  endfunction

endpackage

// File: rtl/cke_slot_decode.sv
module cke_slot_decode
  import cke_track_pkg::*;
#(
  parameter int unsigned NUM_DIMMS = 8
) (
  input  logic                         slot_valid,
  input  logic [CMD_W-1:0]             slot_cmd,
  input  logic                         slot_bcast,
  input  logic [$clog2(NUM_DIMMS)-1:0] slot_sel,
  output logic                         slot_hit,
  output logic                         slot_all,
  output logic [NUM_DIMMS-1:0]         slot_mask
);

  localparam int unsigned SEL_W = $clog2(NUM_DIMMS);

  // Bit mask of the DIMM positions a command writes.
  function automatic logic [NUM_DIMMS-1:0] target_mask(
    input logic             all,
    input logic [SEL_W-1:0] sel
  );
    logic [NUM_DIMMS-1:0] m;
    m = '0;
    if (all) m = '1;
    else     m[sel] = 1'b1;
    return m;
  endfunction

  always_comb begin
    slot_hit  = slot_valid && is_dimm_cke(slot_cmd);
    slot_all  = slot_hit && slot_bcast;
    slot_mask = slot_hit ? target_mask(slot_bcast, slot_sel) : '0;
  end

endmodule

// File: rtl/cke_apply_chain.sv
module cke_apply_chain #(
  parameter int unsigned NUM_DIMMS = 8,
  parameter int unsigned NUM_SLOTS = 3
) (
  input  logic [NUM_DIMMS-1:0]                state_q,
  input  logic [NUM_SLOTS-1:0][NUM_DIMMS-1:0] slot_mask,
  input  logic [NUM_SLOTS-1:0][NUM_DIMMS-1:0] slot_vec,
  output logic [NUM_DIMMS-1:0]                state_next
);

  // Bits under the mask come from the vector, the rest keep the old value.
  function automatic logic [NUM_DIMMS-1:0] merge(
    input logic [NUM_DIMMS-1:0] old_v,
    input logic [NUM_DIMMS-1:0] new_v,
    input logic [NUM_DIMMS-1:0] m
  );
    return (old_v & ~m) | (new_v & m);
  endfunction

  logic [NUM_SLOTS:0][NUM_DIMMS-1:0] stage;

  assign stage[0] = state_q;

  // Ripple through the slots in order: slot 0 first, last slot wins.
  for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_stage
    assign stage[s+1] = merge(stage[s], slot_vec[s], slot_mask[s]);
  end

  assign state_next = stage[NUM_SLOTS];

endmodule

// File: rtl/cke_event_reg.sv
module cke_event_reg #(
  parameter int unsigned NUM_SLOTS = 3,
  parameter int unsigned SEL_W     = 3
) (
  input  logic                            clk,
  input  logic                            rst,
  input  logic [NUM_SLOTS-1:0]            hit,
  input  logic [NUM_SLOTS-1:0]            hit_all,
  input  logic [NUM_SLOTS-1:0][SEL_W-1:0] sel,
  output logic [NUM_SLOTS-1:0]            upd_pulse,
  output logic [NUM_SLOTS-1:0]            upd_all,
  output logic [NUM_SLOTS-1:0][SEL_W-1:0] upd_dimm
);

  for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_evt
    always_ff @(posedge clk) begin
      if (rst) begin
        upd_pulse[s] <= 1'b0;
        upd_all[s]   <= 1'b0;
        upd_dimm[s]  <= '0;
      end else begin
        upd_pulse[s] <= hit[s];
        upd_all[s]   <= hit_all[s];
        upd_dimm[s]  <= (hit[s] && !hit_all[s]) ? sel[s] : '0;
      end
    end
  end

endmodule

// File: rtl/cke_dimm_tracker.sv
module cke_dimm_tracker
  import cke_track_pkg::*;
#(
  parameter int unsigned NUM_DIMMS = 8,
  parameter int unsigned NUM_SLOTS = 3,
  parameter int unsigned SEL_W     = $clog2(NUM_DIMMS)
) (
  input  logic                           clk,
  input  logic                           rst,
  input  logic [NUM_SLOTS-1:0]           slot_valid,
  input  logic [NUM_SLOTS*CMD_W-1:0]     slot_cmd,
  input  logic [NUM_SLOTS*SEL_W-1:0]     slot_sel,
  input  logic [NUM_SLOTS-1:0]           slot_bcast,
  input  logic [NUM_SLOTS*NUM_DIMMS-1:0] slot_enable,
  output logic [NUM_DIMMS-1:0]           cke_state,
  output logic [NUM_SLOTS-1:0]           upd_pulse,
  output logic [NUM_SLOTS*SEL_W-1:0]     upd_dimm,
  output logic [NUM_SLOTS-1:0]           upd_all
);

  // Named internal events, brought out for the assertions.
  logic [NUM_SLOTS-1:0]                slot_hit;
  logic [NUM_SLOTS-1:0]                slot_all;
  logic [NUM_SLOTS-1:0][NUM_DIMMS-1:0] slot_mask;
  logic [NUM_SLOTS-1:0][NUM_DIMMS-1:0] slot_vec;
  logic [NUM_SLOTS-1:0][SEL_W-1:0]     slot_sel_a;
  logic [NUM_SLOTS-1:0][SEL_W-1:0]     upd_dimm_a;
  logic [NUM_DIMMS-1:0]                state_next;

  for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
    assign slot_vec[s]   = slot_enable[s*NUM_DIMMS +: NUM_DIMMS];
    assign slot_sel_a[s] = slot_sel[s*SEL_W +: SEL_W];
    assign upd_dimm[s*SEL_W +: SEL_W] = upd_dimm_a[s];

    cke_slot_decode #(.NUM_DIMMS(NUM_DIMMS)) u_dec (
      .slot_valid (slot_valid[s]),
      .slot_cmd   (slot_cmd[s*CMD_W +: CMD_W]),
      .slot_bcast (slot_bcast[s]),
      .slot_sel   (slot_sel_a[s]),
      .slot_hit   (slot_hit[s]),
      .slot_all   (slot_all[s]),
      .slot_mask  (slot_mask[s])
    );
  end

  cke_apply_chain #(.NUM_DIMMS(NUM_DIMMS), .NUM_SLOTS(NUM_SLOTS)) u_chain (
    .state_q    (cke_state),
    .slot_mask  (slot_mask),
    .slot_vec   (slot_vec),
    .state_next (state_next)
  );

  always_ff @(posedge clk) begin
    if (rst) cke_state <= '0;
    else     cke_state <= state_next;
  end

  cke_event_reg #(.NUM_SLOTS(NUM_SLOTS), .SEL_W(SEL_W)) u_evt (
    .clk       (clk),
    .rst       (rst),
    .hit       (slot_hit),
    .hit_all   (slot_all),
    .sel       (slot_sel_a),
    .upd_pulse (upd_pulse),
    .upd_all   (upd_all),
    .upd_dimm  (upd_dimm_a)
  );

  // ---------------- assertions ----------------

  assert_reset_clears_R1: assert property (@(posedge clk)
    rst |=> (cke_state == '0 && upd_pulse == '0 && upd_all == '0));

  assert_hold_without_event_R5: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && upd_pulse == '0) |-> cke_state == $past(cke_state));

  assert_all_implies_pulse_R8: assert property (@(posedge clk) disable iff (rst)
    (upd_all & ~upd_pulse) == '0);

  for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_chk
    localparam logic [NUM_SLOTS-1:0] ONLY_S = NUM_SLOTS'(1) << s;

    assert_event_source_R2: assert property (@(posedge clk) disable iff (rst)
      upd_pulse[s] |-> ($past(slot_valid[s]) &&
        (($past(slot_cmd[s*CMD_W +: CMD_W]) & DIMM_CKE_MASK) == DIMM_CKE_CODE)));

    assert_single_touches_one_R4: assert property (@(posedge clk) disable iff (rst)
      (upd_pulse == ONLY_S && !upd_all[s]) |->
        (((cke_state ^ $past(cke_state)) & ~(NUM_DIMMS'(1) << upd_dimm_a[s])) == '0));

    assert_last_broadcast_wins_R6: assert property (@(posedge clk) disable iff (rst)
      (upd_all[s] && ((upd_pulse >> (s+1)) == '0)) |->
        cke_state == $past(slot_enable[s*NUM_DIMMS +: NUM_DIMMS]));
  end

endmodule

// File: tb/cke_dimm_tracker_bench.sv
module cke_dimm_tracker_bench;

  localparam int D = 8;
  localparam int S = 3;
  localparam int W = 3;

  typedef struct packed {
    logic [D-1:0]   state;
    logic [S-1:0]   pulse;
    logic [S*W-1:0] dimm;
    logic [S-1:0]   all;
  } exp_t;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [S-1:0]   slot_valid = '0;
  logic [S*8-1:0] slot_cmd = '0;
  logic [S*W-1:0] slot_sel = '0;
  logic [S-1:0]   slot_bcast = '0;
  logic [S*D-1:0] slot_enable = '0;
  logic [D-1:0]   cke_state;
  logic [S-1:0]   upd_pulse;
  logic [S*W-1:0] upd_dimm;
  logic [S-1:0]   upd_all;

  always #2 clk = ~clk;

  cke_dimm_tracker u_cke_dimm_tracker (
    .clk(clk), .rst(rst), .slot_valid(slot_valid), .slot_cmd(slot_cmd),
    .slot_sel(slot_sel), .slot_bcast(slot_bcast), .slot_enable(slot_enable),
    .cke_state(cke_state), .upd_pulse(upd_pulse), .upd_dimm(upd_dimm), .upd_all(upd_all)
  );

  int checks = 0;
  int fails  = 0;
  exp_t  exp_q[$];
  string tag_q[$];
  logic [D-1:0] model = '0;

  // staged slot contents for the next cycle
  logic       t_v[S];
  logic [7:0] t_c[S];
  logic [2:0] t_s[S];
  logic       t_b[S];
  logic [7:0] t_e[S];

  task automatic clear_slots();
    for (int i = 0; i < S; i++) begin
      t_v[i] = 1'b0; t_c[i] = 8'h00; t_s[i] = 3'd0; t_b[i] = 1'b0; t_e[i] = 8'h00;
    end
  endtask

  task automatic put(int i, logic v, logic [7:0] c, logic [2:0] sl, logic b, logic [7:0] e);
    t_v[i] = v; t_c[i] = c; t_s[i] = sl; t_b[i] = b; t_e[i] = e;
  endtask

  // Driver: presents staged slots for one cycle, predicts result, queues it.
  task automatic commit(string tag);
    exp_t x;
    @(negedge clk);
    x = '0;
    for (int i = 0; i < S; i++) begin
      slot_valid[i]        = t_v[i];
      slot_cmd[i*8 +: 8]   = t_c[i];
      slot_sel[i*W +: W]   = t_s[i];
      slot_bcast[i]        = t_b[i];
      slot_enable[i*D +: D] = t_e[i];
      if (t_v[i] && t_c[i][7:1] == 7'b0000111) begin
        for (int d = 0; d < D; d++)
          if (t_b[i] || d == int'(t_s[i])) model[d] = t_e[i][d];
        x.pulse[i] = 1'b1;
        x.all[i]   = t_b[i];
        x.dimm[i*W +: W] = t_b[i] ? 3'd0 : t_s[i];
      end
    end
    x.state = model;
    exp_q.push_back(x);
    tag_q.push_back(tag);
    clear_slots();
  endtask

  // Monitor: compares one queued item per cycle just after the edge.
  always @(posedge clk) begin
    #1;
    if (exp_q.size() > 0) begin
      exp_t e;
      exp_t a;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      a = '{state: cke_state, pulse: upd_pulse, dimm: upd_dimm, all: upd_all};
      checks++;
      if (a !== e) begin
        fails++;
        $display("FAIL %s: state/pulse/dimm/all actual %h/%b/%h/%b expected %h/%b/%h/%b",
                 t, a.state, a.pulse, a.dimm, a.all, e.state, e.pulse, e.dimm, e.all);
      end
    end
  end

  task automatic reset_check(string tag);
    @(negedge clk);
    rst = 1'b1;
    slot_valid = '0;
    @(negedge clk);
    checks++;
    if (cke_state !== '0 || upd_pulse !== '0 || upd_all !== '0) begin
      fails++;
      $display("FAIL %s: state %h pulse %b expected 00 000", tag, cke_state, upd_pulse);
    end
    rst = 1'b0;
    model = '0;
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: run did not complete, actual hung expected done");
    finish_run();
  end

  initial begin
    clear_slots();
    repeat (3) @(negedge clk);
    reset_check("R1 initial reset");
    commit("R1 first cycle after reset idle");

    // R3 R7 R8: broadcast in slot A
    put(0, 1, 8'h0E, 3'd5, 1, 8'hA5); commit("R3 R7 broadcast A5");
    // R4: single DIMM 1 set via slot B, vector has other bits that must be ignored
    put(1, 1, 8'h0E, 3'd1, 0, 8'h5A); commit("R4 single sel1 set");
    // R4: clear DIMM 7 via slot C
    put(2, 1, 8'h0E, 3'd7, 0, 8'h7F); commit("R4 single sel7 clear");
    commit("R7 idle hold");
    // R5: per-rank command and other opcodes ignored
    put(0, 1, 8'h0C, 3'd0, 1, 8'hFF); put(1, 1, 8'h0D, 3'd3, 0, 8'hFF);
    put(2, 1, 8'h1E, 3'd2, 1, 8'h00); commit("R5 per-rank and other opcodes ignored");
    put(0, 1, 8'h00, 3'd0, 1, 8'h00); put(2, 1, 8'h8E, 3'd0, 1, 8'h00);
    commit("R5 nop and near-miss opcodes ignored");
    // R2: valid low ignored; 0x0F accepted
    put(0, 0, 8'h0E, 3'd0, 1, 8'hFF); commit("R2 valid low ignored");
    put(1, 1, 8'h0F, 3'd0, 1, 8'h3C); commit("R2 opcode 0F broadcast");
    // R6: three slots on DIMM 4, later wins
    put(0, 1, 8'h0E, 3'd4, 0, 8'h10); put(1, 1, 8'h0E, 3'd4, 0, 8'h00);
    put(2, 1, 8'h0E, 3'd4, 0, 8'h10); commit("R6 same dimm C sets");
    put(0, 1, 8'h0E, 3'd4, 0, 8'h00); put(1, 1, 8'h0E, 3'd4, 0, 8'h10);
    put(2, 1, 8'h0F, 3'd4, 0, 8'h00); commit("R6 same dimm C clears");
    put(0, 1, 8'h0E, 3'd0, 1, 8'hFF); put(1, 1, 8'h0E, 3'd2, 0, 8'h00);
    commit("R6 broadcast then single");
    put(0, 1, 8'h0E, 3'd0, 0, 8'h00); put(2, 1, 8'h0E, 3'd6, 1, 8'h81);
    commit("R6 single then broadcast override");
    put(0, 1, 8'h0E, 3'd3, 0, 8'hFF); put(1, 1, 8'h0C, 3'd3, 1, 8'h00);
    put(2, 1, 8'h0E, 3'd5, 0, 8'hFF); commit("R6 R5 mixed slots");

    // R9: every select value reaches its own DIMM, from cleared state
    put(0, 1, 8'h0E, 3'd0, 1, 8'h00); commit("R9 clear all");
    for (int k = 0; k < D; k++) begin
      put(k % S, 1, 8'h0E, 3'(k), 0, 8'hFF); commit("R9 select sweep set");
    end
    for (int k = D - 1; k >= 0; k--) begin
      put((k + 1) % S, 1, 8'h0F, 3'(k), 0, 8'h00); commit("R9 select sweep clear");
    end

    put(1, 1, 8'h0E, 3'd0, 1, 8'hC3); commit("R3 broadcast C3");
    reset_check("R1 mid-run reset");
    commit("R1 R8 idle after reset");
    put(2, 1, 8'h0E, 3'd2, 0, 8'h04); commit("R8 event after reset");
    commit("R8 pulse drops");
    repeat (3) @(negedge clk);
    finish_run();
  end

endmodule